// File: doc/BRIEF.md
# Selected-Cell Averaging Slot Sequencer

This block drives the time-weighted averaging step of an analog cell-matching routine. A fixed budget of clock cycles is shared equally among the cells that a selection mask marks as live. Each live cell's held value is connected to an external integrator for its share of that budget, so the charge that collects equals the mean of the selected values. No digital accumulator and no divide of a sum are involved. The integrator itself lies outside this block.

On a start pulse the block captures the mask and counts its set bits, one bit per clock. It then divides the budget (cell count times cycles per cell, 1280 with the defaults) by that count in a restoring divider, one quotient bit per clock. It then walks the live cells in ascending index order. For each one it raises a connect strobe with the cell index for exactly one slot of quotient cycles. Unselected cells cost no cycles. The remainder of the division is reported, because it is the part of the budget that the cycle granularity cannot place. An empty mask ends the run at once and raises an empty flag.

Top module: `slot_avg_sequencer`

## Requirements
- R1: After reset, connectEn, done, busy and emptyFlag are 0, and slotLen and slotRem read 0.
- R2: From the first connect cycle, slotLen equals floor(NUM_CELLS*CYCLES_PER_CELL / n) and slotRem equals the remainder of that division, where n is the number of set bits in the captured mask (a set bit at position i selects cell i).
- R3: With a non-empty mask, connectEn first reads 1 in the cycle that follows the 139th rising edge after the edge that samples startPulse: 128 counting edges and 11 divider edges.
- R4: Each selected cell is connected for exactly slotLen consecutive cycles. Cells are visited in ascending index order with no idle cycle between them, so the connect phase lasts n*slotLen cycles.
- R5: connectIdx never names a cell whose mask bit was clear at capture, and only one index is presented per cycle.
- R6: done is a one-cycle pulse in the cycle after the last connect cycle. busy is 1 from the edge after start until done, and 0 in the cycle after done.
- R7: With an all-zero mask, done rises after the 128th edge following the start edge. emptyFlag is then 1 and no connect cycle occurs. emptyFlag holds until the next accepted start.
- R8: The mask is captured only at the accepted start edge. A startPulse or a mask change while busy is 1 has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins a sequence when the block is idle |
| selMask | input | NUM_CELLS | Live-cell mask; bit i selects cell i |
| connectEn | output | 1 | Integrator connect strobe |
| connectIdx | output | IDX_W | Index of the cell being connected |
| slotLen | output | BUD_W | Cycles per cell (quotient) |
| slotRem | output | CNT_W | Unplaced budget cycles (remainder) |
| emptyFlag | output | 1 | Last sequence had no selected cell |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench counts falling edges from the clock edge that samples startPulse. It expects the first connect cycle at count 139, done at 139 plus n*slotLen, and, for an empty mask, done at count 128. slotLen and slotRem are compared in the first connect cycle. A scoreboard queue holds one expected index per connect cycle, and a monitor pops an entry on every falling edge where connectEn is high. This covers order, slot length and the absence of gaps. A second start and an inverted mask are applied mid-run, and the expected timing and indices are left unchanged to test that both are ignored.

// File: rtl/slot_avg_pkg.sv
package slot_avg_pkg;

  typedef struct packed {
    logic loadMask;   // capture mask, clear counters and empty flag
    logic countStep;  // add one mask bit to the population count
    logic divInit;    // preload divider with the budget
    logic divStep;    // one restoring-divide iteration
    logic slotStep;   // advance slot counter, retire cell at slot end
    logic setEmpty;   // record an empty selection
  } ctrlStrobes_t;

  typedef struct packed {
    logic scanLast;   // counting the final mask bit
    logic countZero;  // population will be zero after this step
    logic divLast;    // final divider iteration
    logic slotLast;   // final cycle of the current slot
    logic lastCell;   // only one selected cell remains
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DIV,
    ST_RUN,
    ST_FIN
  } seqState_t;

endpackage

// File: rtl/slot_avg_datapath.sv
module slot_avg_datapath
  import slot_avg_pkg::*;
#(
  parameter int NUM_CELLS       = 128,
  parameter int CYCLES_PER_CELL = 10,
  localparam int IDX_W  = $clog2(NUM_CELLS),
  localparam int CNT_W  = $clog2(NUM_CELLS + 1),
  localparam int BUDGET = NUM_CELLS * CYCLES_PER_CELL,
  localparam int BUD_W  = $clog2(BUDGET + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CELLS-1:0] selMask,
  input  ctrlStrobes_t         strobes,
  input  logic                 runActive,
  output dpStatus_t            status,
  output logic [IDX_W-1:0]     curIdx,
  output logic [BUD_W-1:0]     slotLen,
  output logic [CNT_W-1:0]     slotRem,
  output logic                 emptyFlag
);

  localparam int ITER_W = $clog2(BUD_W);

  logic [NUM_CELLS-1:0] maskReg;
  logic [NUM_CELLS-1:0] pending;
  logic [IDX_W-1:0]     scanIdx;
  logic [CNT_W-1:0]     popCnt;
  logic [CNT_W-1:0]     remReg;
  logic [BUD_W-1:0]     dqReg;
  logic [ITER_W-1:0]    iter;
  logic [BUD_W-1:0]     slotCnt;
  logic                 emptyReg;

  // Mask capture and retirement of finished cells
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      pending <= '0;
    end else if (strobes.loadMask) begin
      maskReg <= selMask;
      pending <= selMask;
    end else if (strobes.slotStep && status.slotLast) begin
      pending[curIdx] <= 1'b0;
    end
  end

  // Sequential population count, one bit per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx <= '0;
      popCnt  <= '0;
    end else if (strobes.loadMask) begin
      scanIdx <= '0;
      popCnt  <= '0;
    end else if (strobes.countStep) begin
      scanIdx <= scanIdx + IDX_W'(1);
      popCnt  <= popCnt + CNT_W'(maskReg[scanIdx]);
    end
  end

  // Restoring divider: budget / popCnt, one quotient bit per cycle
  logic [CNT_W:0] trial;
  logic [CNT_W:0] divisorExt;
  logic           trialGe;

  always_comb begin
    trial      = {remReg, dqReg[BUD_W-1]};
    divisorExt = {1'b0, popCnt};
    trialGe    = (trial >= divisorExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      dqReg  <= '0;
      iter   <= '0;
    end else if (strobes.divInit) begin
      remReg <= '0;
      dqReg  <= BUD_W'(BUDGET);
      iter   <= '0;
    end else if (strobes.divStep) begin
      if (trialGe) begin
        remReg <= CNT_W'(trial - divisorExt);
      end else begin
        remReg <= trial[CNT_W-1:0];
      end
      dqReg <= {dqReg[BUD_W-2:0], trialGe};
      iter  <= iter + ITER_W'(1);
    end
  end

  // Slot counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (strobes.loadMask) begin
      slotCnt <= '0;
    end else if (strobes.slotStep) begin
      if (status.slotLast) slotCnt <= '0;
      else                 slotCnt <= slotCnt + BUD_W'(1);
    end
  end

  // Empty flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 emptyReg <= 1'b0;
    else if (strobes.loadMask) emptyReg <= 1'b0;
    else if (strobes.setEmpty) emptyReg <= 1'b1;
  end

  // Lowest pending cell
  logic found;
  always_comb begin
    curIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (pending[i] && !found) begin
        curIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    status.scanLast  = (scanIdx == IDX_W'(NUM_CELLS - 1));
    status.countZero = (popCnt == '0) && !maskReg[scanIdx];
    status.divLast   = (iter == ITER_W'(BUD_W - 1));
    status.slotLast  = (slotCnt == dqReg - BUD_W'(1));
    status.lastCell  = ((pending & (pending - NUM_CELLS'(1))) == '0);
  end

  assign slotLen   = dqReg;
  assign slotRem   = remReg;
  assign emptyFlag = emptyReg;

  // The connected cell was selected at capture
  assert_connect_selected_R5: assert property (@(posedge clk) disable iff (!rstN)
    runActive |-> maskReg[curIdx]);

  // The index holds within a slot
  assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runActive && slotCnt != '0) |-> (curIdx == $past(curIdx)));

  // The remainder is below the divisor while connecting
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    runActive |-> (remReg < popCnt));

endmodule

// File: rtl/slot_avg_control.sv
module slot_avg_control
  import slot_avg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         runActive,
  output logic         busy,
  output logic         done
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobes.loadMask = 1'b1;
          nextState        = ST_COUNT;
        end
      end
      ST_COUNT: begin
        strobes.countStep = 1'b1;
        if (status.scanLast) begin
          if (status.countZero) begin
            strobes.setEmpty = 1'b1;
            nextState        = ST_FIN;
          end else begin
            strobes.divInit = 1'b1;
            nextState       = ST_DIV;
          end
        end
      end
      ST_DIV: begin
        strobes.divStep = 1'b1;
        if (status.divLast) nextState = ST_RUN;
      end
      ST_RUN: begin
        strobes.slotStep = 1'b1;
        if (status.slotLast && status.lastCell) nextState = ST_FIN;
      end
      ST_FIN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign runActive = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  // done lasts one cycle and the block is idle afterwards
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // A start while busy does not re-capture the mask
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse) |-> !strobes.loadMask);

endmodule

// File: rtl/slot_avg_sequencer.sv
module slot_avg_sequencer
  import slot_avg_pkg::*;
#(
  parameter int NUM_CELLS       = 128,
  parameter int CYCLES_PER_CELL = 10,
  localparam int IDX_W  = $clog2(NUM_CELLS),
  localparam int CNT_W  = $clog2(NUM_CELLS + 1),
  localparam int BUDGET = NUM_CELLS * CYCLES_PER_CELL,
  localparam int BUD_W  = $clog2(BUDGET + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic [NUM_CELLS-1:0] selMask,
  output logic                 connectEn,
  output logic [IDX_W-1:0]     connectIdx,
  output logic [BUD_W-1:0]     slotLen,
  output logic [CNT_W-1:0]     slotRem,
  output logic                 emptyFlag,
  output logic                 busy,
  output logic                 done
);

  ctrlStrobes_t     strobes;
  dpStatus_t        status;
  logic             runActive;
  logic [IDX_W-1:0] curIdx;

  slot_avg_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .status     (status),
    .strobes    (strobes),
    .runActive  (runActive),
    .busy       (busy),
    .done       (done)
  );

  slot_avg_datapath #(
    .NUM_CELLS       (NUM_CELLS),
    .CYCLES_PER_CELL (CYCLES_PER_CELL)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .selMask   (selMask),
    .strobes   (strobes),
    .runActive (runActive),
    .status    (status),
    .curIdx    (curIdx),
    .slotLen   (slotLen),
    .slotRem   (slotRem),
    .emptyFlag (emptyFlag)
  );

  assign connectEn  = runActive;
  assign connectIdx = curIdx;

  // Indices never move backwards within a run
  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (connectEn && $past(connectEn)) |-> (connectIdx >= $past(connectIdx)));

  // An empty selection never connects a cell
  assert_empty_noconnect_R7: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> !connectEn);

endmodule

// File: tb/test_slot_avg_sequencer.sv
module test_slot_avg_sequencer;

  localparam int NC     = 128;
  localparam int BUDGET = 1280;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [NC-1:0] selMask = '0;
  logic          connectEn;
  logic [6:0]    connectIdx;
  logic [10:0]   slotLen;
  logic [7:0]    slotRem;
  logic          emptyFlag;
  logic          busy;
  logic          done;

  int total = 0;
  int bad   = 0;
  int expQ[$];

  always #4 clk = ~clk;

  slot_avg_sequencer i_slot_avg_sequencer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .selMask(selMask),
    .connectEn(connectEn), .connectIdx(connectIdx), .slotLen(slotLen),
    .slotRem(slotRem), .emptyFlag(emptyFlag), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: one expected index per connect cycle (R4, R5)
  always @(negedge clk) begin
    if (rstN && connectEn) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5", "unexpected connect idx", connectIdx, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        chk(connectIdx == 7'(e), "R4", "connect index", connectIdx, e);
      end
    end
  end

  task automatic runCase(input logic [NC-1:0] m);
    int cnt, q, r, n, firstN, doneN, conns;
    cnt = $countones(m);
    q = (cnt == 0) ? 0 : BUDGET / cnt;
    r = (cnt == 0) ? 0 : BUDGET % cnt;
    for (int i = 0; i < NC; i++)
      if (m[i]) for (int k = 0; k < q; k++) expQ.push_back(i);
    @(negedge clk);
    selMask = m;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    selMask = ~m;            // R8: late mask change
    n = 0; firstN = -1; doneN = -1; conns = 0;
    while (doneN < 0 && n < 4000) begin
      if (n == 60) startPulse = 1'b1;   // R8: start while busy
      if (n == 61) startPulse = 1'b0;
      if (connectEn) begin
        conns++;
        if (firstN < 0) begin
          firstN = n;
          chk(n == 139, "R3", "first connect cycle", n, 139);
          chk(slotLen == 11'(q), "R2", "slotLen", slotLen, q);
          chk(slotRem == 8'(r), "R2", "slotRem", slotRem, r);
        end
      end
      if (done) doneN = n;
      else begin
        @(negedge clk);
        n++;
      end
    end
    if (cnt == 0) begin
      chk(doneN == 128, "R7", "empty done cycle", doneN, 128);
      chk(emptyFlag == 1'b1, "R7", "emptyFlag", emptyFlag, 1);
      chk(conns == 0, "R7", "connects on empty", conns, 0);
    end else begin
      chk(doneN == 139 + cnt * q, "R6", "done cycle", doneN, 139 + cnt * q);
      chk(conns == cnt * q, "R4", "connect cycles", conns, cnt * q);
      chk(emptyFlag == 1'b0, "R7", "emptyFlag clear", emptyFlag, 0);
    end
    chk(expQ.size() == 0, "R4", "leftover expected", expQ.size(), 0);
    expQ.delete();
    @(negedge clk);
    chk(done == 1'b0, "R6", "done after pulse", done, 0);
    chk(busy == 1'b0, "R6", "busy after done", busy, 0);
    if (cnt == 0) chk(emptyFlag == 1'b1, "R7", "emptyFlag held", emptyFlag, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [NC-1:0] m;
    repeat (3) @(negedge clk);
    chk(connectEn == 0 && done == 0 && busy == 0, "R1", "reset strobes",
        {connectEn, done, busy}, 0);
    chk(emptyFlag == 0, "R1", "reset emptyFlag", emptyFlag, 0);
    chk(slotLen == 0 && slotRem == 0, "R1", "reset slot regs", slotLen, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCase({NC{1'b1}});                    // 10 rem 0
    m = '0; m[127] = 1'b1; runCase(m);      // 1280 rem 0
    m = '0; m[0] = 1; m[5] = 1; m[100] = 1; runCase(m); // 426 rem 2
    m = '0; for (int i = 0; i < 97; i++) m[i + 20] = 1'b1;
    runCase(m);                             // 13 rem 19
    runCase('0);                            // empty
    m = '0; for (int i = 0; i < 7; i++) m[i * 18 + 3] = 1'b1;
    runCase(m);                             // 182 rem 6

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule